// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block produces four independent pulse-width-modulated outputs. It is configured through a simple 32-bit memory-mapped register port. Each channel keeps two programmed values: a period, which is the length of one output cycle in clock cycles, and a level duration, which is how many cycles at the start of each period the output sits at its duration level. Channel control bits share common registers, and channel n always owns bit n. There is a run bit, a reload handshake bit, a polarity bit and an output-enable bit.

The programmed values never drive the counter directly. Each channel keeps private working copies of them. Those copies are captured when the channel's run bit goes from 0 to 1. While the channel is running they are refreshed only by a reload handshake: software writes the channel's reload bit to 1 and then back to 0. The falling edge of that bit stages the new values, and they replace the working copies at the next period boundary. Software can therefore retune a running channel and never get a partial or mixed period.

The output-enable bits are passed straight to per-channel pin-direction outputs. A set bit means the channel drives its pin.

Top module: `pwm_quad_shadow`

## Requirements
- R1: After reset every register reads 0, all PWM outputs and output enables are 0, and the status register reads 0.
- R2: Register offsets: channel n level duration at 0x00+8n, channel n period at 0x04+8n, polarity 0x40, run 0x44, status 0x48, reload 0x4C, output enable 0xD0. Period and duration fields are 30 bits wide and bits 31:30 read as 0.
- R3: When the run bit of a channel rises, the programmed period P and duration D are captured. One cycle later the counter starts at 0. The output repeats every P cycles, with the duration level for counter values below D and the opposite level for the rest.
- R4: Writes to the period or duration registers of a running channel do not change its output until the reload bit is written 1 and then 0. The new values then take effect at the next period boundary, so a period is never cut short.
- R5: With polarity bit 0 the duration level is low and the rest of the period is high. With polarity bit 1 the duration level is high and the rest is low.
- R6: A duration of 0 holds the output at the non-duration (active) level for the whole period, giving 100% duty.
- R7: A duration greater than or equal to the period holds the output at the duration level for the whole period.
- R8: A programmed period of 0 or 1 behaves as a period of 2.
- R9: While a channel's run bit is 0 its output is low, whatever its polarity.
- R10: Status bit n is 1 while channel n is running and 0 otherwise. Writes to the status offset have no effect.
- R11: Output-enable port bit n equals bit n of the output-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 4 | PWM level per channel |
| pwm_oe | output | 4 | Pin drive enable per channel |

## Verification
The embedded assertions check the following on every cycle of a running channel:
- the counter stays below the working period;
- the working period is never under 2;
- the counter steps by exactly one except at a wrap;
- the working copies change only at a period boundary, so no partial period can appear;
- the channel reports idle right after its run bit is cleared.

The waveform shapes under each polarity and the duty extremes can only be shown by the bench scenarios, which compare the pin cycle by cycle. The same holds for the 0-or-1 period clamp, for ignoring register writes until the reload handshake, for register readback and for the read-only status.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CNT_W    = 30;
  localparam logic [7:0]  OFS_POL  = 8'h40;
  localparam logic [7:0]  OFS_RUN  = 8'h44;
  localparam logic [7:0]  OFS_STAT = 8'h48;
  localparam logic [7:0]  OFS_UPD  = 8'h4C;
  localparam logic [7:0]  OFS_OE   = 8'hD0;
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  function automatic logic [CNT_W-1:0] clamp_per(input logic [CNT_W-1:0] p);
    return (p < MIN_PER) ? MIN_PER : p;
  endfunction
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BUS_W-1:0]           wdata,
  output logic [BUS_W-1:0]           rdata,
  input  logic [NCH-1:0]             status,
  output logic [NCH-1:0][CNT_W-1:0]  cfg_per,
  output logic [NCH-1:0][CNT_W-1:0]  cfg_dur,
  output logic [NCH-1:0]             pol,
  output logic [NCH-1:0]             run,
  output logic [NCH-1:0]             upd,
  output logic [NCH-1:0]             oe
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;
  localparam int unsigned CPAD  = BUS_W - NCH;

  logic [NCH-1:0][CNT_W-1:0] per_d, dur_d;
  logic [NCH-1:0]            pol_d, run_d, upd_d, oe_d;
  logic [NCH-1:0]            per_en, dur_en;
  logic                      pol_en, run_en, upd_en, oe_en;

  // Write decode and next-state
  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      dur_en[n] = we && (addr == ADDR_W'(8 * n));
      per_en[n] = we && (addr == ADDR_W'(8 * n + 4));
      per_d[n]  = per_en[n] ? wdata[CNT_W-1:0] : cfg_per[n];
      dur_d[n]  = dur_en[n] ? wdata[CNT_W-1:0] : cfg_dur[n];
    end
    pol_en = we && (addr == ADDR_W'(OFS_POL));
    run_en = we && (addr == ADDR_W'(OFS_RUN));
    upd_en = we && (addr == ADDR_W'(OFS_UPD));
    oe_en  = we && (addr == ADDR_W'(OFS_OE));
    pol_d  = pol_en ? wdata[NCH-1:0] : pol;
    run_d  = run_en ? wdata[NCH-1:0] : run;
    upd_d  = upd_en ? wdata[NCH-1:0] : upd;
    oe_d   = oe_en  ? wdata[NCH-1:0] : oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_per <= '0;
      cfg_dur <= '0;
      pol     <= '0;
      run     <= '0;
      upd     <= '0;
      oe      <= '0;
    end else begin
      cfg_per <= per_d;
      cfg_dur <= dur_d;
      pol     <= pol_d;
      run     <= run_d;
      upd     <= upd_d;
      oe      <= oe_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr == ADDR_W'(8 * n))     rdata = {{PAD_W{1'b0}}, cfg_dur[n]};
      if (addr == ADDR_W'(8 * n + 4)) rdata = {{PAD_W{1'b0}}, cfg_per[n]};
    end
    if (addr == ADDR_W'(OFS_POL))  rdata = {{CPAD{1'b0}}, pol};
    if (addr == ADDR_W'(OFS_RUN))  rdata = {{CPAD{1'b0}}, run};
    if (addr == ADDR_W'(OFS_STAT)) rdata = {{CPAD{1'b0}}, status};
    if (addr == ADDR_W'(OFS_UPD))  rdata = {{CPAD{1'b0}}, upd};
    if (addr == ADDR_W'(OFS_OE))   rdata = {{CPAD{1'b0}}, oe};
  end

  AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(run)) else $error("run bits changed without a write"); // R10
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
  import pwmq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             upd,
  input  logic             pol,
  input  logic [CNT_W-1:0] cfg_per,
  input  logic [CNT_W-1:0] cfg_dur,
  output logic             pwm,
  output logic             busy
);
  logic             run_q, upd_q, active, pend;
  logic [CNT_W-1:0] cnt, wper, wdur, sper, sdur;
  logic             run_q_d, upd_q_d, active_d, pend_d;
  logic [CNT_W-1:0] cnt_d, wper_d, wdur_d, sper_d, sdur_d;
  logic             start_rise, upd_fall, wrap;

  assign start_rise = run && !run_q;
  assign upd_fall   = upd_q && !upd;
  assign wrap       = active && (cnt == wper - CNT_W'(1));

  always_comb begin
    run_q_d  = run;
    upd_q_d  = upd;
    active_d = active;
    pend_d   = pend;
    cnt_d    = cnt;
    wper_d   = wper;
    wdur_d   = wdur;
    sper_d   = sper;
    sdur_d   = sdur;
    if (!run) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
      cnt_d    = '0;
    end else if (start_rise) begin
      active_d = 1'b1;
      cnt_d    = '0;
      wper_d   = clamp_per(cfg_per);
      wdur_d   = cfg_dur;
      pend_d   = 1'b0;
    end else if (active) begin
      cnt_d = wrap ? '0 : cnt + CNT_W'(1);
      if (wrap && pend) begin
        wper_d = sper;
        wdur_d = sdur;
        pend_d = 1'b0;
      end
      if (upd_fall) begin
        sper_d = clamp_per(cfg_per);
        sdur_d = cfg_dur;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      upd_q  <= 1'b0;
      active <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      wper   <= MIN_PER;
      wdur   <= '0;
      sper   <= MIN_PER;
      sdur   <= '0;
    end else begin
      run_q  <= run_q_d;
      upd_q  <= upd_q_d;
      active <= active_d;
      pend   <= pend_d;
      cnt    <= cnt_d;
      wper   <= wper_d;
      wdur   <= wdur_d;
      sper   <= sper_d;
      sdur   <= sdur_d;
    end
  end

  // Duration phase at level 'pol', remainder at '~pol'; low whenever stopped
  assign pwm  = run && active && ((cnt < wdur) ? pol : !pol);
  assign busy = active;

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < wper)) else $error("counter past period"); // R3
  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wper >= MIN_PER)) else $error("working period under 2"); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(wrap)) |-> (cnt == $past(cnt) + CNT_W'(1)))
    else $error("counter skipped"); // R3
  AST_WORK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(wrap)) |-> ($stable(wper) && $stable(wdur)))
    else $error("working copy changed mid-period"); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> !busy) else $error("busy after stop"); // R10
endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow
  import pwmq_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  logic [NCH-1:0][CNT_W-1:0] cfg_per, cfg_dur;
  logic [NCH-1:0]            pol, run, upd, oe, busy;

  pwmq_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .status(busy),
    .cfg_per(cfg_per), .cfg_dur(cfg_dur), .pol(pol), .run(run),
    .upd(upd), .oe(oe)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwmq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .run(run[n]), .upd(upd[n]), .pol(pol[n]),
      .cfg_per(cfg_per[n]), .cfg_dur(cfg_dur[n]),
      .pwm(pwm_out[n]), .busy(busy[n])
    );
  end

  assign pwm_oe = oe;
endmodule

// File: tb/pwm_quad_shadow_bench.sv
module pwm_quad_shadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [3:0]  run_mask = '0;

  always #5 clk = ~clk;

  pwm_quad_shadow u_pwm_quad_shadow (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic start_ch(int ch);
    run_mask[ch] = 1'b1;
    wr(8'h44, {28'd0, run_mask});
    @(negedge clk); // counter at 0 from here
  endtask

  task automatic stop_ch(int ch);
    run_mask[ch] = 1'b0;
    wr(8'h44, {28'd0, run_mask});
  endtask

  // Compare n cycles starting at the current sample (counter 0)
  task automatic wave(string tag, int ch, int p, int d, bit pl, int n);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(tag, {31'd0, pwm_out[ch]}, {31'd0, (((i % p) < d) ? pl : ~pl)});
    end
  endtask

  // Move to the first cycle of a period (duration phase begins)
  task automatic sync(int ch, bit pl);
    logic prev;
    prev = pwm_out[ch];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (prev == ~pl && pwm_out[ch] == pl) return;
      prev = pwm_out[ch];
    end
    chk("sync", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pwm_out", {28'd0, pwm_out}, 32'd0);
    chk("R1 pwm_oe", {28'd0, pwm_oe}, 32'd0);
    rd(8'h04, v); chk("R1 period reg", v, 32'd0);
    rd(8'h44, v); chk("R1 run reg", v, 32'd0);
    rd(8'h48, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R2 ch2 period 30-bit", v, 32'h3FFF_FFFF);
    wr(8'h18, 32'h0000_0123);
    rd(8'h18, v); chk("R2 ch3 duration offset", v, 32'h123);
    wr(8'h40, 32'h5);
    rd(8'h40, v); chk("R2 polarity reg", v, 32'h5);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_basic();
    wr(8'h04, 32'd5); wr(8'h00, 32'd2);
    start_ch(0);
    wave("R3 R5 ch0 P5 D2 pol0", 0, 5, 2, 1'b0, 15);
  endtask

  task automatic t_full();
    wr(8'h0C, 32'd4); wr(8'h08, 32'd0);
    start_ch(1);
    wave("R6 ch1 D0 full duty", 1, 4, 0, 1'b0, 12);
  endtask

  task automatic t_dur_big();
    wr(8'h14, 32'd3); wr(8'h10, 32'd7);
    start_ch(2);
    wave("R7 ch2 D>=P", 2, 3, 7, 1'b0, 9);
  endtask

  task automatic t_clamp();
    wr(8'h1C, 32'd1); wr(8'h18, 32'd1);
    start_ch(3);
    wave("R8 ch3 P1 as 2", 3, 2, 1, 1'b0, 10);
  endtask

  task automatic t_status();
    logic [31:0] v;
    rd(8'h48, v); chk("R10 status running", v, 32'hF);
    wr(8'h48, 32'h0);
    rd(8'h48, v); chk("R10 status write ignored", v, 32'hF);
  endtask

  task automatic t_shadow();
    wr(8'h04, 32'd4); wr(8'h00, 32'd1);
    sync(0, 1'b0);
    wave("R4 ch0 old values kept", 0, 5, 2, 1'b0, 15);
    wr(8'h4C, 32'h1); wr(8'h4C, 32'h0);
    repeat (12) @(negedge clk);
    sync(0, 1'b0);
    wave("R4 ch0 reloaded P4 D1", 0, 4, 1, 1'b0, 12);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(8'h40, 32'h1);
    stop_ch(0);
    for (int i = 0; i < 6; i++) begin
      chk("R9 stopped low pol1", {31'd0, pwm_out[0]}, 32'd0);
      @(negedge clk);
    end
    rd(8'h48, v); chk("R10 status after stop", v, 32'hE);
  endtask

  task automatic t_pol1();
    wr(8'h04, 32'd6); wr(8'h00, 32'd2);
    start_ch(0);
    wave("R5 R3 ch0 pol1 P6 D2", 0, 6, 2, 1'b1, 18);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_oe();
    wr(8'hD0, 32'hA);
    chk("R11 oe port", {28'd0, pwm_oe}, 32'hA);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_full();
    t_dur_big();
    t_clamp();
    t_status();
    t_shadow();
    t_stop();
    t_pol1();
    t_oe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule